// File: doc/BRIEF.md
# SPI Host with Selectable Word Length

This block is a register-controlled SPI host. Software writes a 16-bit control word that holds eight direct chip-select enables, a unit enable, the serial clock idle level, a three-bit clock ratio code, a two-bit word length code and a completion interrupt enable. Writing the data register while the unit is enabled and idle starts a transfer of 8, 16, 24 or 32 bits. Transmit data goes out most significant bit first, and receive data comes back right-aligned in the same register.

The serial clock comes from a prescaler that is cleared while the unit is off and counts system clocks while it is on. Each bit takes two prescaler ticks. On the first tick the clock leaves its idle level and the output bit changes. On the second tick the clock returns to idle and the input bit is sampled. A busy flag can be read back, and an optional one-clock interrupt pulse marks the end of each transfer.

Top module: `spi_host_wsz`

## Requirements
- R1: Chip-select output `cs_n[i]` is low exactly while control bit i (bits 7:0) is set, whether or not the unit is enabled.
- R2: While enable (control bit 8) is set, the prescaler ticks once every N system clocks, counted from the edge at which enable was first seen set. N is chosen by control bits 12:10: 0→2, 1→4, 2→8, 3→64, 4→128, 5→1024, 6→2048, 7→4096. While enable is clear the prescaler stays cleared.
- R3: A data-register write (`wr_sel`=1) starts a transfer when enable is set and busy is clear. Busy (control read bit 31) is set from the next clock. A data write while busy or while disabled is ignored.
- R4: Control bits 14:13 set the length to 8×(code+1) bits. The first bit sent is bit 8×(code+1)−1 of the written word, then each lower bit in turn.
- R5: `sclk` rests at the level of control bit 9 whenever no transfer runs. It moves to the opposite level on the first tick of each bit and returns on the second tick.
- R6: `mosi` takes the next transmit bit on the first tick of each bit and holds it until the next first tick.
- R7: `miso` is sampled on the second tick of each bit and shifted into bit 0. After a transfer, a data read (`rd_sel`=1) returns the received bits right-aligned, with zeros above them.
- R8: When busy falls at the end of a transfer and control bit 15 is set, `irq` is high for exactly that one clock.
- R9: Clearing enable aborts a running transfer. Busy clears and `sclk` returns to idle one clock later, and no interrupt is raised.
- R10: A control read (`rd_sel`=0) returns bits 15:0 as last written, zeros in bits 30:16, and busy in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control/status, 1 data |
| rd_data | output | 32 | Read data (combinational) |
| cs_n | output | 8 | Active-low chip selects |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transfer-complete pulse |

## Verification
Transfers are run with all four word lengths, across both clock idle levels and several clock ratios including a large one. This separates errors in the start bit position, the bit count and the edge polarity. The input line carries a pseudo-random stream that changes every clock, so sampling on the wrong tick or shifting into the wrong end shows up as wrong received data. Further cases cover a data write issued mid-transfer, a data write while disabled, a disable in the middle of a 32-bit transfer, and a transfer with the interrupt enable clear. These separate the ignore, abort and interrupt-gating paths from a normal completion.

// File: rtl/spi_host_pkg.sv
// Shared constants and helpers for the SPI host.
// Assumes a 32-bit register interface; the control field positions are fixed.
package spi_host_pkg;
    localparam int CTRL_EN      = 8;
    localparam int CTRL_CPOL    = 9;
    localparam int CTRL_PRE_LO  = 10;
    localparam int CTRL_SIZE_LO = 13;
    localparam int CTRL_IRQEN   = 15;
    localparam int CTRL_W       = 16;
    localparam int CS_COUNT     = 8;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    // Power-of-two exponent of the clock ratio for each code.
    function automatic int unsigned prescale_log2(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 7;
            3'd5:    return 10;
            3'd6:    return 11;
            default: return 12;
        endcase
    endfunction
endpackage

// File: rtl/spi_host_prescaler.sv
// Tick generator: counts system clocks while enabled and pulses once every
// 2**k clocks, where k comes from the ratio code. Assumes CNT_W >= 12.
module spi_host_prescaler
    import spi_host_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Low-bit mask whose all-ones state marks a tick.
    always_comb mask = CNT_W'((32'd1 << prescale_log2(sel)) - 32'd1);

    // Free-running count, held at zero while the unit is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && ((cnt_q & mask) == mask);

    // R2: every ratio is at least two, so ticks never come back to back.
    a_r2_no_adjacent_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spi_host_shifter.sv
// Shift engine: runs one transfer of nbits bits, two ticks per bit. The
// first tick drives the clock active and the next output bit; the second
// restores idle and shifts the input bit into bit 0. Assumes load_word is
// already aligned so that its first bit sits at the top.
module spi_host_shifter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] load_word,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              cpol,
    input  logic              miso,
    output logic              busy,
    output logic              finish,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] word
);
    logic              busy_q;
    logic              phase_q;
    logic              act_q;
    logic              mosi_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;

    // Final sampling tick of the last bit.
    assign finish = busy_q && tick && phase_q && (left_q == CNT_W'(1));

    // Transfer sequencing: abort, load, or advance one half-bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            act_q   <= 1'b0;
            mosi_q  <= 1'b0;
            shreg_q <= '0;
            left_q  <= '0;
        end else if (!en) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            act_q   <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            act_q   <= 1'b0;
            shreg_q <= load_word;
            left_q  <= nbits;
        end else if (busy_q && tick) begin
            if (!phase_q) begin
                act_q   <= 1'b1;
                mosi_q  <= shreg_q[DATA_W-1];
                phase_q <= 1'b1;
            end else begin
                act_q   <= 1'b0;
                shreg_q <= {shreg_q[DATA_W-2:0], miso};
                phase_q <= 1'b0;
                left_q  <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign sclk = cpol ^ act_q;
    assign mosi = mosi_q;
    assign word = shreg_q;

    // R5: the clock sits at its idle level whenever no transfer runs.
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (sclk == cpol));
    // R4: a running transfer always has between 1 and DATA_W bits left.
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (left_q != '0 && left_q <= CNT_W'(DATA_W)));
endmodule

// File: rtl/spi_host_wsz.sv
// SPI host top: control register, chip selects, word alignment, readback
// and completion interrupt. Assumes DATA_W is 32 so that the status bit
// lands in bit 31; reads are combinational.
module spi_host_wsz
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CTRL_W-1:0] ctrl_q;
    logic              en;
    logic              tick;
    logic              start;
    logic              busy;
    logic              finish;
    logic              irq_q;
    logic [1:0]        size_code;
    logic [CNT_W-1:0]  nbits;
    logic [DATA_W-1:0] load_word;
    logic [DATA_W-1:0] word;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ctrl_q <= '0;
        else if (wr_en && wr_sel == SEL_CTRL)  ctrl_q <= wr_data[CTRL_W-1:0];
    end

    assign en        = ctrl_q[CTRL_EN];
    assign size_code = ctrl_q[CTRL_SIZE_LO +: 2];
    assign nbits     = CNT_W'((int'(size_code) + 1) * 8);
    assign load_word = wr_data << (DATA_W - int'(nbits));
    assign start     = wr_en && (wr_sel == SEL_DATA) && en;
    assign cs_n      = ~ctrl_q[CS_COUNT-1:0];

    spi_host_prescaler #(.CNT_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .sel  (ctrl_q[CTRL_PRE_LO +: 3]),
        .tick (tick)
    );

    spi_host_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .start    (start),
        .load_word(load_word),
        .nbits    (nbits),
        .cpol     (ctrl_q[CTRL_CPOL]),
        .miso     (miso),
        .busy     (busy),
        .finish   (finish),
        .sclk     (sclk),
        .mosi     (mosi),
        .word     (word)
    );

    // Completion pulse, gated by the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= finish && ctrl_q[CTRL_IRQEN];
    end

    assign irq = irq_q;

    // Register readback mux.
    always_comb begin
        if (rd_sel == SEL_CTRL) rd_data = {busy, {(DATA_W-CTRL_W-1){1'b0}}, ctrl_q};
        else                    rd_data = word;
    end

    // R3: an accepted data write makes the unit busy on the next clock.
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && en && !busy) |=> busy);
    // R8: the interrupt appears only in the clock in which busy has just fallen.
    a_r8_irq_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));
    // R8: the interrupt lasts a single clock.
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R9: with the unit disabled, no transfer survives the next edge.
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
endmodule

// File: tb/spi_host_wsz_tb.sv
// Bench: a behavioural reference model updated at each rising edge and
// compared with the design at each falling edge.
module spi_host_wsz_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  cs_n;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit begun = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    logic [15:0] m_ctrl;
    int          m_cnt;
    logic        m_busy, m_phase, m_act, m_mosi, m_irq;
    logic [31:0] m_sh;
    int          m_left;

    always #2.5 clk = ~clk;

    spi_host_wsz u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
    );

    function automatic int ratio(input logic [2:0] c);
        case (c)
            3'd0: return 2;    3'd1: return 4;    3'd2: return 8;
            3'd3: return 64;   3'd4: return 128;  3'd5: return 1024;
            3'd6: return 2048; default: return 4096;
        endcase
    endfunction

    function automatic logic [31:0] ctl(input logic [7:0] cs, input bit en, input bit cpol,
                                        input logic [2:0] pre, input logic [1:0] sz, input bit ie);
        return {16'b0, ie, sz, pre, cpol, en, cs};
    endfunction

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        bit en, tk;
        int div;
        begun = 1;
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = 0; m_busy = 0; m_phase = 0; m_act = 0;
            m_mosi = 0; m_sh = '0; m_left = 0; m_irq = 0;
        end else begin
            en  = m_ctrl[8];
            div = ratio(m_ctrl[12:10]);
            tk  = en && ((m_cnt % div) == div - 1);
            m_irq = 0;
            if (!en) begin
                m_busy = 0; m_phase = 0; m_act = 0;
            end else if (wr_en && wr_sel && !m_busy) begin
                m_left = 8 * (int'(m_ctrl[14:13]) + 1);
                m_sh = wr_data << (32 - m_left);
                m_busy = 1; m_phase = 0; m_act = 0;
            end else if (m_busy && tk) begin
                if (!m_phase) begin
                    m_act = 1; m_mosi = m_sh[31]; m_phase = 1;
                end else begin
                    m_act = 0; m_sh = {m_sh[30:0], miso}; m_phase = 0;
                    m_left = m_left - 1;
                    if (m_left == 0) begin m_busy = 0; m_irq = m_ctrl[15]; end
                end
            end
            m_cnt = en ? m_cnt + 1 : 0;
            if (wr_en && !wr_sel) m_ctrl = wr_data[15:0];
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (begun) begin
            cmp("R1 chip selects", {24'b0, cs_n}, {24'b0, ~m_ctrl[7:0]});
            cmp("R5 R2 R9 sclk level/timing", {31'b0, sclk}, {31'b0, m_ctrl[9] ^ m_act});
            cmp("R6 R4 mosi bit order", {31'b0, mosi}, {31'b0, m_mosi});
            cmp("R8 irq pulse", {31'b0, irq}, {31'b0, m_irq});
            if (rd_sel) cmp("R7 received word", rd_data, m_sh);
            else        cmp("R10 R3 R9 control/busy", rd_data, {m_busy, 15'b0, m_ctrl});
        end
    end

    // Pseudo-random input line and read selector, changed just after each edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = lfsr[0];
        rd_sel = lfsr[3];
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40000 && m_busy; i++) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R1: chip selects while disabled; R3: data write while disabled is ignored
        wr(1'b0, ctl(8'hA5, 0, 0, 3'd0, 2'd0, 1));
        wr(1'b1, 32'h0000_00FF);
        repeat (10) @(posedge clk);
        // R4 8-bit, /2, idle low, irq on
        wr(1'b0, ctl(8'h01, 1, 0, 3'd0, 2'd0, 1));
        wr(1'b1, 32'hFFFF_FFC3);
        wait_idle();
        // R4 16-bit, /4, idle high
        wr(1'b0, ctl(8'h02, 1, 1, 3'd1, 2'd1, 1));
        wr(1'b1, 32'h1234_ABCD);
        wait_idle();
        // R4 24-bit, /8, R3 write while busy ignored
        wr(1'b0, ctl(8'h04, 1, 0, 3'd2, 2'd2, 1));
        wr(1'b1, 32'h00A5_5A3C);
        repeat (30) @(posedge clk);
        wr(1'b1, 32'hDEAD_BEEF);
        wait_idle();
        // R4 32-bit, /2, R8 irq disabled
        wr(1'b0, ctl(8'h80, 1, 1, 3'd0, 2'd3, 0));
        wr(1'b1, 32'h8001_7FFE);
        wait_idle();
        // R9 abort mid-transfer
        wr(1'b0, ctl(8'h10, 1, 1, 3'd2, 2'd3, 1));
        wr(1'b1, 32'hCAFE_F00D);
        repeat (60) @(posedge clk);
        wr(1'b0, ctl(8'h10, 0, 1, 3'd2, 2'd3, 1));
        repeat (20) @(posedge clk);
        // R2 large ratio /64, 8-bit
        wr(1'b0, ctl(8'h00, 1, 0, 3'd3, 2'd0, 1));
        wr(1'b1, 32'h0000_0096);
        wait_idle();
        // R2 /128 with a 16-bit word
        wr(1'b0, ctl(8'hFF, 1, 1, 3'd4, 2'd1, 1));
        wr(1'b1, 32'h0000_5AA5);
        wait_idle();
        summary();
        $finish;
    end
endmodule